// File: doc/BRIEF.md
# Interlace-Capable Raster Field Sequencer

This block produces the vertical raster count and field sequencing for a character-based video controller that drives NTSC timing in either progressive or interlaced form. It runs its own 65-clock line period, advances a 9-bit raster value that the processor reads, and tracks which field is on screen. It marks each field start with a one-clock pulse and opens a vertical sync window near the top of every field.

The interlace mode comes from one bit of a control register. A change to that bit is not applied at once. The field length depends on the active mode and on the field parity. A field in progress can still be cut short, or allowed to overrun, because the end-of-field comparator looks at the live register bit. When interlace is cleared while the last line of an interlaced field is running, the comparator never matches. The counter then runs on to 511 and wraps to 0.

Top module: `raster_field_seq`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) gives `raster` = 0, `field_odd` = 0, `field_start` = 0 and `vsync` = 0. It also selects progressive mode with the interlace bit cleared and the line clock at position 0.
- R2: A line lasts 65 clocks. During line clocks 0 to 31, `raster` reads the line number. From clock 32 to clock 64 it reads the line number plus one, wrapping modulo 512. The single exception is the last line of an upper field, which is covered in R6.
- R3: In progressive mode a field holds lines 0 to 260. The last line reads 260 and then 261, and the next line starts at 0.
- R4: A write with `cfg_we` high stores `cfg_wdata[7]` as the interlace bit, and bits 6:0 have no effect. A change to the active mode takes effect only at the next field boundary. The first interlaced field after progressive mode is always a lower field.
- R5: `field_odd` is 1 throughout a lower field and 0 throughout an upper field. Consecutive interlaced fields alternate between the two. `field_odd` is 0 in progressive fields.
- R6: A lower field ends after line 261, whose halves read 261 and then 262. An upper field ends after line 262, whose halves read 262 and then 0.
- R7: `field_start` is high for exactly one clock: the first clock of line 0 of every field. At that clock `raster` is 0.
- R8: The end-of-field comparator uses the live interlace bit, combined with the active mode. If interlace is cleared during the final line of an interlaced field, that field does not end. The count continues through 511, and the wrap to 0 is a field boundary.
- R9: When the interlace bit is cleared during an interlaced field, before its final line, that field ends after line 260. The next field is progressive.
- R10: In progressive and lower fields, `vsync` is high for whole lines 3 to 5. In upper fields it rises at clock 32 of line 3 and falls at clock 32 of line 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-derived clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data; bit 7 is the interlace enable |
| raster | output | 9 | Processor-visible raster count |
| field_odd | output | 1 | 1 in lower interlaced fields |
| field_start | output | 1 | One-clock pulse at the start of each field |
| vsync | output | 1 | Vertical sync window |

## Verification
The delicate coincidence is a control write that lands on the last line of a field, at the moment the end-of-field comparator is evaluated. A clear there must suppress the boundary and send the count up to 511, where deferred sampling alone would predict a normal wrap. The bench provokes this with a directed clear during line 261 of a lower field. It also scatters random writes across many line and clock positions. A cycle-by-cycle reference built in the bench judges the outcome, and literal readings of 262, 300 and the 511-to-0 wrap are checked as well. A second coincidence is a write on a field's first clock, where the bit must not be adopted until the following field.

// File: rtl/raster_field_seq.sv
module raster_field_seq #(
  parameter int LINE_CLKS  = 65,
  parameter int MID_CLK    = 32,
  parameter int CNT_W      = 9,
  parameter int PROG_LAST  = 260,
  parameter int LOWER_LAST = 261,
  parameter int UPPER_LAST = 262,
  parameter int VS_FIRST   = 3,
  parameter int VS_LAST    = 5,
  parameter int IL_BIT     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [CNT_W-1:0] raster,
  output logic             field_odd,
  output logic             field_start,
  output logic             vsync
);
  localparam int HW = $clog2(LINE_CLKS);
  localparam logic [HW-1:0]    H_END = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0]    H_MID = HW'(MID_CLK - 1);
  localparam logic [CNT_W-1:0] L_PROG  = CNT_W'(PROG_LAST);
  localparam logic [CNT_W-1:0] L_LOWER = CNT_W'(LOWER_LAST);
  localparam logic [CNT_W-1:0] L_UPPER = CNT_W'(UPPER_LAST);
  localparam logic [CNT_W-1:0] L_MAX   = {CNT_W{1'b1}};

  logic [HW-1:0]    hcnt;
  logic [CNT_W-1:0] line, rc;
  logic il_live, act, odd, start_q, vs_q;

  function automatic logic in_vs(input logic [CNT_W-1:0] l);
    return (l >= CNT_W'(VS_FIRST)) && (l <= CNT_W'(VS_LAST));
  endfunction

  wire line_end = (hcnt == H_END);
  wire mid      = (hcnt == H_MID);
  wire upper    = act & ~odd;

  wire [CNT_W-1:0] last = (il_live & act) ? (odd ? L_LOWER : L_UPPER) : L_PROG;
  wire fld_end = line_end & ((line == last) | (line == L_MAX));

  wire [CNT_W-1:0] nline = fld_end ? '0 : line + 1'b1;
  wire nact   = fld_end ? il_live : act;
  wire nodd   = fld_end ? (il_live & (~act | ~odd)) : odd;
  wire nupper = nact & ~nodd;
  wire [CNT_W-1:0] mid_val = (upper && line == L_UPPER) ? '0 : line + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      line    <= '0;
      rc      <= '0;
      il_live <= 1'b0;
      act     <= 1'b0;
      odd     <= 1'b0;
      start_q <= 1'b0;
      vs_q    <= 1'b0;
    end else begin
      if (cfg_we) il_live <= cfg_wdata[IL_BIT];
      start_q <= fld_end;
      if (line_end) begin
        hcnt <= '0;
        line <= nline;
        rc   <= nline;
        act  <= nact;
        odd  <= nodd;
        if (!nupper) vs_q <= in_vs(nline);
      end else begin
        hcnt <= hcnt + 1'b1;
        if (mid) begin
          rc <= mid_val;
          if (upper) vs_q <= in_vs(line);
        end
      end
    end
  end

  assign raster      = rc;
  assign field_odd   = odd;
  assign field_start = start_q;
  assign vsync       = vs_q;

  p_start_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
    field_start |-> (raster == '0 && hcnt == '0));
  p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
    field_start |=> !field_start);
  p_prog_parity_r5: assert property (@(posedge clk) disable iff (rst)
    !act |-> !field_odd);
  p_first_lower_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> field_odd);
  p_mode_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    (act != $past(act)) |-> field_start);
  p_mid_step_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(hcnt) == H_MID) |-> (raster == $past(raster) + CNT_W'(1) || raster == '0));
  p_line_start_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (hcnt != '0 && hcnt != HW'(MID_CLK)) |-> $stable(raster));
endmodule

// File: tb/sim_raster_field_seq.sv
module sim_raster_field_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [8:0] raster;
  logic field_odd, field_start, vsync;

  always #2 clk = ~clk;

  raster_field_seq u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .raster(raster), .field_odd(field_odd), .field_start(field_start), .vsync(vsync)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state, built from the requirements
  int m_h, m_line, m_rc;
  bit m_il, m_act, m_odd, m_start, m_vs;

  function automatic bit vs_rng(int l);
    return (l >= 3) && (l <= 5);
  endfunction

  function automatic int last_line(bit il, bit a, bit o);
    if (il && a) return o ? 261 : 262;
    return 260;
  endfunction

  always @(posedge clk) begin : model
    int nl;
    bit fe, na, no;
    if (rst) begin
      m_h <= 0; m_line <= 0; m_rc <= 0; m_il <= 0;
      m_act <= 0; m_odd <= 0; m_start <= 0; m_vs <= 0;
    end else begin
      fe = (m_h == 64) && (m_line == last_line(m_il, m_act, m_odd) || m_line == 511);
      nl = fe ? 0 : (m_line + 1) % 512;
      na = fe ? m_il : m_act;
      no = fe ? (m_il && !(m_act && m_odd)) : m_odd;
      m_start <= fe;
      if (cfg_we) m_il <= cfg_wdata[7];
      if (m_h == 64) begin
        m_h <= 0; m_line <= nl; m_rc <= nl; m_act <= na; m_odd <= no;
        if (!(na && !no)) m_vs <= vs_rng(nl);
      end else begin
        m_h <= m_h + 1;
        if (m_h == 31) begin
          m_rc <= (m_act && !m_odd && m_line == 262) ? 0 : (m_line + 1) % 512;
          if (m_act && !m_odd) m_vs <= vs_rng(m_line);
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act_v, int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (line %0d clk %0d)", tag, act_v, exp_v, m_line, m_h);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(raster == 9'(m_rc), "R2 raster", int'(raster), m_rc);
      chk(field_odd == m_odd, "R5 field_odd", int'(field_odd), int'(m_odd));
      chk(field_start == m_start, "R7 field_start", int'(field_start), int'(m_start));
      chk(vsync == m_vs, "R10 vsync", int'(vsync), int'(m_vs));
    end
  end

  task automatic run_to(int l, int h);
    @(negedge clk);
    while (!(m_line == l && m_h == h)) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    cfg_wdata = d;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (198000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1207));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(raster == 0 && field_odd == 0 && field_start == 0 && vsync == 0,
        "R1 reset state", int'(raster), 0);

    // progressive field end
    run_to(260, 10); chk(raster == 260, "R3 last line first half", int'(raster), 260);
    run_to(260, 40); chk(raster == 261, "R3 last line second half", int'(raster), 261);
    run_to(0, 0);
    chk(field_start == 1 && raster == 0, "R7 start pulse", int'(field_start), 1);
    wr(8'h7F);                              // R4: bits 6:0 only
    run_to(100, 0); wr(8'h80);              // R4: set, deferred
    run_to(200, 0); chk(field_odd == 0, "R4 deferred set", int'(field_odd), 0);
    run_to(260, 64); @(negedge clk);
    chk(raster == 0 && field_start == 1, "R3 wrap after 260 with bit set", int'(raster), 0);
    chk(field_odd == 1, "R4 first field lower", int'(field_odd), 1);

    // lower field
    run_to(261, 10); chk(raster == 261, "R6 lower last first half", int'(raster), 261);
    run_to(261, 40); chk(raster == 262, "R6 lower last second half", int'(raster), 262);
    run_to(261, 64); @(negedge clk);
    chk(field_start == 1 && field_odd == 0, "R5 upper follows lower", int'(field_odd), 0);

    // upper field
    run_to(3, 10); chk(vsync == 0, "R10 upper vsync late", int'(vsync), 0);
    run_to(3, 40); chk(vsync == 1, "R10 upper vsync mid rise", int'(vsync), 1);
    run_to(6, 10); chk(vsync == 1, "R10 upper vsync held", int'(vsync), 1);
    run_to(6, 40); chk(vsync == 0, "R10 upper vsync mid fall", int'(vsync), 0);
    run_to(262, 10); chk(raster == 262, "R6 upper last first half", int'(raster), 262);
    run_to(262, 40); chk(raster == 0, "R6 upper last second half", int'(raster), 0);
    run_to(262, 64); @(negedge clk);
    chk(field_start == 1 && field_odd == 1, "R5 lower follows upper", int'(field_odd), 1);
    run_to(4, 10); chk(vsync == 1, "R10 lower vsync whole line", int'(vsync), 1);

    // clear during final line of lower field: runaway
    run_to(261, 40); wr(8'h00);
    run_to(262, 10); chk(raster == 262, "R8 no field end", int'(raster), 262);
    run_to(300, 10); chk(raster == 300, "R8 runaway count", int'(raster), 300);
    run_to(511, 10); chk(raster == 511, "R8 reaches 511", int'(raster), 511);
    run_to(511, 40); chk(raster == 0, "R8 mid wrap", int'(raster), 0);
    run_to(511, 64); @(negedge clk);
    chk(field_start == 1 && field_odd == 0, "R8 wrap is boundary", int'(field_start), 1);

    // clear mid-field: short interlaced field
    run_to(5, 0); wr(8'h80);
    run_to(0, 0); chk(field_odd == 1, "R4 lower after set", int'(field_odd), 1);
    run_to(100, 0); wr(8'h00);
    run_to(260, 64); @(negedge clk);
    chk(field_start == 1 && raster == 0, "R9 ends after 260", int'(raster), 0);
    chk(field_odd == 0, "R9 progressive next", int'(field_odd), 0);

    // random writes, checked each clock against the reference
    repeat (24) begin
      repeat ($urandom_range(800, 2600)) @(negedge clk);
      wr(8'($urandom));
    end
    repeat (200) @(negedge clk);
    finish_run();
  end
endmodule